// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block sits between a synchronous host and an external asynchronous static RAM. The RAM has a 15-bit address, an 8-bit data bus and three active-low strobes: select, write and output enable. The host issues single-beat read or write requests. The controller turns each request into a strobe sequence in which every minimum interval of the RAM is met. Each interval is a whole number of clock cycles, computed at elaboration from a clock-period parameter and from the RAM's nanosecond limits.

Each interval in cycles is the nanosecond limit divided by the clock period, rounded up. A limit of zero still takes one cycle, so that no two strobe or bus edges fall on the same clock.
- A write asserts select and write enable on the same edge and keeps output enable off throughout. It drives data for the whole overlap and holds data and address one cycle past the rising strobes.
- A read asserts select and output enable together for one full read-cycle time. The data bus is captured on the last cycle. Afterwards the controller waits out the RAM's bus-release time before it can accept the next request.

The host can also ask for the low-power retention state. The controller deselects the RAM and reports readiness once select has been high long enough. After a later exit request it counts the recovery time before it accepts accesses again.

The data bus is split into an output, an output-enable and an input, ready for a pad cell. The state machine has ten states:
- IDLE
- WR_SETUP, WR_PULSE, WR_HOLD
- RD_SETUP, RD_ACCESS, RD_TURN
- RET_DESEL, RET_HOLD, RET_RECOV

The transitions are:
- IDLE→WR_SETUP: request with write set.
- IDLE→RD_SETUP: request with write clear.
- IDLE→RET_DESEL: retention request and no access request.
- Each counted state moves to the next state of its chain when its interval expires: WR_SETUP→WR_PULSE→WR_HOLD→IDLE, RD_SETUP→RD_ACCESS→RD_TURN→IDLE, RET_DESEL→RET_HOLD.
- RET_HOLD→RET_RECOV: exit request.
- RET_RECOV→IDLE: recovery interval expires.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: During and after reset, select, write enable and output enable are high (inactive), the data bus is not driven, and ack, busy and ret_ready are low.
- R2: A write lowers mem_cs_n and mem_we_n on the same edge and keeps both low for exactly 15 cycles at the default 5 ns period (the largest of write pulse, select-to-end and data-setup limits). mem_oe_n stays high whenever mem_we_n is low.
- R3: During a write the bus is driven with the request's wdata for every cycle of the strobe overlap and for one cycle after the strobes rise. This one cycle is the data hold.
- R4: A read lowers mem_cs_n and mem_oe_n for exactly 17 cycles (read cycle time) with mem_we_n high and the bus undriven. rdata takes the value on mem_dq_i in the last of those cycles and keeps it until the next read.
- R5: The bus is never driven while mem_oe_n is low, nor within 6 cycles (bus-release time) after mem_oe_n rises.
- R6: ack is a one-cycle pulse. Counting the accepting edge as edge 0, ack is visible after edge 17 for a write and after edge 24 for a read. busy is high from the accepting edge until the ack cycle, in which it is low.
- R7: A request is accepted only in IDLE. A request raised while busy or in retention is dropped and produces no ack and no RAM access.
- R8: When req and ret_req are high in the same IDLE cycle, the access is served and the retention request is dropped.
- R9: A retention request in IDLE deselects the RAM. ret_ready rises one cycle after acceptance, once select has been high for one cycle, and select stays high while ret_ready is high.
- R10: A ret_exit pulse while ret_ready is high clears ret_ready and starts a 17-cycle recovery. busy falls after edge 17 counted from the exit edge as edge 0, and accesses then work normally.
- R11: mem_addr carries the accepted address from the setup cycle to the end of the access and is stable whenever mem_cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled in IDLE |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 15 | Access address |
| wdata | input | 8 | Write data |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |
| busy | output | 1 | Controller not in IDLE |
| ret_req | input | 1 | Retention entry request, sampled in IDLE |
| ret_exit | input | 1 | Retention exit request, sampled in RET_HOLD |
| ret_ready | output | 1 | RAM deselected long enough for supply lowering |
| mem_addr | output | 15 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_o | output | 8 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 8 | Data from the RAM |

## Verification
The bench measures each strobe's low time and the delay from a rising output enable to the next bus drive. A controller that shortened the write overlap or the read access by one count would show a wrong run length. One that skipped the turnaround would drive into a still-active RAM and trip the contention monitor. It raises a request in the middle of a write and during retention, and then reads the target address back. A controller that queued such a request would change memory or emit an extra ack. It also raises access and retention requests together, and times the recovery count, where an off-by-one would show up as a wrong busy fall cycle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_SETUP,
        ST_RD_ACCESS,
        ST_RD_TURN,
        ST_RET_DESEL,
        ST_RET_HOLD,
        ST_RET_RECOV
    } ctrl_state_e;

    // Whole cycles covering a limit; a zero limit still costs one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned lim_ns,
                                              input int unsigned per_ns);
        int unsigned c;
        c = (lim_ns + per_ns - 1) / per_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
    parameter int unsigned AW = 15,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic          capture,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] rdata
);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= dq_in;
        end
    end

    assign mem_addr = addr_q;
    assign dq_out   = wdata_q;
    assign rdata    = rdata_q;

    // R4: captured data only moves on a capture strobe
    p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> (rdata == $past(rdata_q)));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W      = 5,
    parameter int unsigned SETUP_CYC  = 1,
    parameter int unsigned WPULSE_CYC = 15,
    parameter int unsigned WHOLD_CYC  = 1,
    parameter int unsigned RACC_CYC   = 17,
    parameter int unsigned RTURN_CYC  = 6,
    parameter int unsigned DESEL_CYC  = 1,
    parameter int unsigned RECOV_CYC  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             ret_req,
    input  logic             ret_exit,
    input  logic             tdone,
    output logic             tload,
    output logic [CNT_W-1:0] tload_val,
    output logic             accept,
    output logic             capture,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe,
    output logic             ack,
    output logic             busy,
    output logic             ret_ready
);

    ctrl_state_e state_q, state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    state_nxt = req_we ? ST_WR_SETUP : ST_RD_SETUP;
                end else if (ret_req) begin
                    state_nxt = ST_RET_DESEL;
                end
            end
            ST_WR_SETUP:  if (tdone) state_nxt = ST_WR_PULSE;
            ST_WR_PULSE:  if (tdone) state_nxt = ST_WR_HOLD;
            ST_WR_HOLD:   if (tdone) state_nxt = ST_IDLE;
            ST_RD_SETUP:  if (tdone) state_nxt = ST_RD_ACCESS;
            ST_RD_ACCESS: if (tdone) state_nxt = ST_RD_TURN;
            ST_RD_TURN:   if (tdone) state_nxt = ST_IDLE;
            ST_RET_DESEL: if (tdone) state_nxt = ST_RET_HOLD;
            ST_RET_HOLD:  if (ret_exit) state_nxt = ST_RET_RECOV;
            ST_RET_RECOV: if (tdone) state_nxt = ST_IDLE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // interval length of the state being entered
    always_comb begin
        tload_val = '0;
        unique case (state_nxt)
            ST_WR_SETUP:  tload_val = CNT_W'(SETUP_CYC - 1);
            ST_WR_PULSE:  tload_val = CNT_W'(WPULSE_CYC - 1);
            ST_WR_HOLD:   tload_val = CNT_W'(WHOLD_CYC - 1);
            ST_RD_SETUP:  tload_val = CNT_W'(SETUP_CYC - 1);
            ST_RD_ACCESS: tload_val = CNT_W'(RACC_CYC - 1);
            ST_RD_TURN:   tload_val = CNT_W'(RTURN_CYC - 1);
            ST_RET_DESEL: tload_val = CNT_W'(DESEL_CYC - 1);
            ST_RET_RECOV: tload_val = CNT_W'(RECOV_CYC - 1);
            default:      tload_val = '0;
        endcase
    end

    assign tload   = (state_nxt != state_q);
    assign accept  = (state_q == ST_IDLE) && req;
    assign capture = (state_q == ST_RD_ACCESS) && tdone;

    // registered outputs, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n      <= 1'b1;
            we_n      <= 1'b1;
            oe_n      <= 1'b1;
            dq_oe     <= 1'b0;
            ack       <= 1'b0;
            busy      <= 1'b0;
            ret_ready <= 1'b0;
        end else begin
            cs_n      <= !((state_nxt == ST_WR_PULSE) || (state_nxt == ST_RD_ACCESS));
            we_n      <= !(state_nxt == ST_WR_PULSE);
            oe_n      <= !(state_nxt == ST_RD_ACCESS);
            dq_oe     <= (state_nxt == ST_WR_PULSE) || (state_nxt == ST_WR_HOLD);
            ack       <= (state_nxt == ST_IDLE) &&
                         ((state_q == ST_WR_HOLD) || (state_q == ST_RD_TURN));
            busy      <= (state_nxt != ST_IDLE);
            ret_ready <= (state_nxt == ST_RET_HOLD);
        end
    end

    // R6: completion is a single-cycle pulse and coincides with idle
    p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    p_ack_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !busy);

    // R9: RAM stays deselected while retention is reported
    p_ret_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ready |-> (cs_n && we_n && oe_n && !dq_oe));

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned AW            = 15,
    parameter int unsigned DW            = 8,
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned T_WC_NS       = 85,
    parameter int unsigned T_WP_NS       = 60,
    parameter int unsigned T_CW_NS       = 75,
    parameter int unsigned T_AW_NS       = 70,
    parameter int unsigned T_DW_NS       = 35,
    parameter int unsigned T_AS_NS       = 0,
    parameter int unsigned T_WR_NS       = 0,
    parameter int unsigned T_RC_NS       = 85,
    parameter int unsigned T_AA_NS       = 85,
    parameter int unsigned T_ACS_NS      = 85,
    parameter int unsigned T_OE_NS       = 45,
    parameter int unsigned T_HZ_NS       = 30,
    parameter int unsigned T_OH_NS       = 10,
    parameter int unsigned T_DESEL_NS    = 0,
    parameter int unsigned T_RECOV_NS    = 85
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic          busy,
    input  logic          ret_req,
    input  logic          ret_exit,
    output logic          ret_ready,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_we_n,
    output logic          mem_oe_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);

    localparam int unsigned P = CLK_PERIOD_NS;
    localparam int unsigned SETUP_CYC  = ns_to_cyc(T_AS_NS, P);
    localparam int unsigned WPULSE_CYC = max2(max2(ns_to_cyc(T_WP_NS, P), ns_to_cyc(T_CW_NS, P)),
                                              max2(ns_to_cyc(T_AW_NS, P), ns_to_cyc(T_DW_NS, P)));
    localparam int unsigned WSUM_CYC   = SETUP_CYC + WPULSE_CYC;
    localparam int unsigned WC_CYC     = ns_to_cyc(T_WC_NS, P);
    localparam int unsigned WHOLD_CYC  = max2(ns_to_cyc(T_WR_NS, P),
                                              (WC_CYC > WSUM_CYC) ? (WC_CYC - WSUM_CYC) : 0);
    localparam int unsigned RACC_CYC   = max2(max2(ns_to_cyc(T_RC_NS, P), ns_to_cyc(T_AA_NS, P)),
                                              max2(ns_to_cyc(T_ACS_NS, P), ns_to_cyc(T_OE_NS, P)));
    localparam int unsigned RTURN_CYC  = max2(ns_to_cyc(T_HZ_NS, P), ns_to_cyc(T_OH_NS, P));
    localparam int unsigned DESEL_CYC  = ns_to_cyc(T_DESEL_NS, P);
    localparam int unsigned RECOV_CYC  = ns_to_cyc(T_RECOV_NS, P);
    localparam int unsigned MAX_CYC    = max2(max2(max2(WPULSE_CYC, WHOLD_CYC), max2(RACC_CYC, RTURN_CYC)),
                                              max2(max2(DESEL_CYC, RECOV_CYC), SETUP_CYC));
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

    logic             tload;
    logic [CNT_W-1:0] tload_val;
    logic             tdone;
    logic             accept;
    logic             capture;

    sram_interval_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tload),
        .load_val (tload_val),
        .done     (tdone)
    );

    sram_seq_fsm #(
        .CNT_W      (CNT_W),
        .SETUP_CYC  (SETUP_CYC),
        .WPULSE_CYC (WPULSE_CYC),
        .WHOLD_CYC  (WHOLD_CYC),
        .RACC_CYC   (RACC_CYC),
        .RTURN_CYC  (RTURN_CYC),
        .DESEL_CYC  (DESEL_CYC),
        .RECOV_CYC  (RECOV_CYC)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (we),
        .ret_req   (ret_req),
        .ret_exit  (ret_exit),
        .tdone     (tdone),
        .tload     (tload),
        .tload_val (tload_val),
        .accept    (accept),
        .capture   (capture),
        .cs_n      (mem_cs_n),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .dq_oe     (mem_dq_oe),
        .ack       (ack),
        .busy      (busy),
        .ret_ready (ret_ready)
    );

    sram_data_path #(.AW(AW), .DW(DW)) dpath_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .addr_in  (addr),
        .wdata_in (wdata),
        .capture  (capture),
        .dq_in    (mem_dq_i),
        .mem_addr (mem_addr),
        .dq_out   (mem_dq_o),
        .rdata    (rdata)
    );

    // R2: output enable is off and select is on whenever write enable is low
    p_oe_off_in_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_cs_n));

    // R3: bus driven through the whole write overlap
    p_drive_in_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R5: no drive against an enabled RAM output, nor right after it turns off
    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    p_release_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> !mem_dq_oe);

    // R11: address frozen while the RAM is selected
    p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R7: nothing is accepted outside idle
    p_accept_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ack && !ret_ready) |=> $stable(mem_addr) || $past(!busy));

endmodule

// File: tb/sram_strobe_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_tb_top;

    // expected cycle figures at 5 ns
    localparam int EXP_WE_RUN  = 15;
    localparam int EXP_OE_RUN  = 17;
    localparam int EXP_WR_LAT  = 18;   // ack seen at the 18th negedge after the accept edge
    localparam int EXP_RD_LAT  = 25;
    localparam int EXP_REC_LAT = 18;
    localparam int TURN_CYC    = 6;

    // vector = {we, addr[14:0], wdata, expected rdata}
    localparam logic [31:0] VEC [8] = '{
        {1'b1, 15'h0011, 8'hA5, 8'h00},
        {1'b1, 15'h7F22, 8'h3C, 8'h00},
        {1'b1, 15'h4033, 8'hFF, 8'h00},
        {1'b1, 15'h0044, 8'h00, 8'h00},
        {1'b0, 15'h0011, 8'h00, 8'hA5},
        {1'b0, 15'h7F22, 8'h00, 8'h3C},
        {1'b0, 15'h4033, 8'h00, 8'hFF},
        {1'b0, 15'h0044, 8'h00, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, ret_req = 1'b0, ret_exit = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ack, busy, ret_ready;
    logic [7:0]  rdata;
    logic [14:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_o, mem_dq_i;

    always #2.5 clk = ~clk;

    sram_strobe_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .ack(ack), .rdata(rdata), .busy(busy), .ret_req(ret_req), .ret_exit(ret_exit),
        .ret_ready(ret_ready), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // small RAM model, indexed by the low address byte
    logic [7:0] mem_model [256];
    assign mem_dq_i = (!mem_cs_n && mem_we_n && !mem_oe_n) ? mem_model[mem_addr[7:0]] : 8'h00;

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus monitor
    logic        prev_we_n = 1'b1, prev_oe_n = 1'b1;
    int          we_run = 0, oe_run = 0, last_we_run = 0, last_oe_run = 0;
    int          oe_hi_cnt = 100;
    int          bad_write_strobe = 0, bad_drive = 0, bad_contention = 0, n_writes = 0;
    logic [14:0] wr_addr_seen = '0;
    logic [7:0]  wr_data_seen = '0;

    always @(negedge clk) begin
        if (!mem_we_n) begin
            we_run++;
            if (!mem_oe_n || mem_cs_n) bad_write_strobe++;
            if (!mem_dq_oe || mem_dq_o != wdata_latched) bad_drive++;
        end else if (!prev_we_n) begin
            last_we_run = we_run;
            we_run = 0;
            n_writes++;
            if (!mem_dq_oe) bad_drive++;
            wr_addr_seen = mem_addr;
            wr_data_seen = mem_dq_o;
            mem_model[mem_addr[7:0]] = mem_dq_o;
        end
        if (!mem_oe_n) begin
            oe_run++;
            oe_hi_cnt = 0;
        end else begin
            if (!prev_oe_n) begin
                last_oe_run = oe_run;
                oe_run = 0;
            end
            oe_hi_cnt++;
        end
        if (mem_dq_oe && (!mem_oe_n || oe_hi_cnt <= TURN_CYC)) bad_contention++;
        prev_we_n = mem_we_n;
        prev_oe_n = mem_oe_n;
    end

    logic [7:0] wdata_latched = '0;

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic access(input bit w, input logic [14:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int lat);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d;
        if (w) wdata_latched = d;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!ack && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        rd = rdata;
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int lat;
        int extra_ack;
        bit saw_ready;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 strobes in reset",
            {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
        chk(!ack && !busy && !ret_ready, "R1 status in reset", {ack, busy, ret_ready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy, "R1 idle after reset",
            {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe, busy}, 5'b11100);

        // table walk
        foreach (VEC[i]) begin
            access(VEC[i][31], VEC[i][30:16], VEC[i][15:8], rd, lat);
            if (VEC[i][31]) begin
                chk(lat == EXP_WR_LAT, "R6 write ack latency", lat, EXP_WR_LAT);
                chk(wr_addr_seen == VEC[i][30:16], "R11 write address", wr_addr_seen, VEC[i][30:16]);
                chk(wr_data_seen == VEC[i][15:8], "R3 write data", wr_data_seen, VEC[i][15:8]);
                chk(last_we_run == EXP_WE_RUN, "R2 write overlap length", last_we_run, EXP_WE_RUN);
            end else begin
                chk(lat == EXP_RD_LAT, "R6 read ack latency", lat, EXP_RD_LAT);
                chk(rd == VEC[i][7:0], "R4 read data", rd, VEC[i][7:0]);
                chk(last_oe_run == EXP_OE_RUN, "R4 read strobe length", last_oe_run, EXP_OE_RUN);
            end
            @(negedge clk);
            chk(!ack && !busy, "R6 ack single cycle", {ack, busy}, 0);
        end
        chk(bad_write_strobe == 0, "R2 oe high and cs low during write", bad_write_strobe, 0);
        chk(bad_drive == 0, "R3 bus driven through overlap and hold", bad_drive, 0);
        chk(bad_contention == 0, "R5 no drive in release window", bad_contention, 0);

        // R4: rdata holds across a write
        access(1'b1, 15'h0066, 8'h5C, rd, lat);
        chk(rdata == 8'h00, "R4 rdata kept across write", rdata, 8'h00);

        // R7: request during a write is dropped
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 15'h0077; wdata = 8'h12; wdata_latched = 8'h12;
        @(negedge clk);
        req = 1'b0;
        repeat (3) @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 15'h0011; wdata = 8'h77;
        @(negedge clk);
        req = 1'b0;
        extra_ack = 0;
        repeat (60) begin
            @(negedge clk);
            if (ack) extra_ack++;
        end
        chk(extra_ack == 1, "R7 only one ack for two requests", extra_ack, 1);
        access(1'b0, 15'h0011, 8'h00, rd, lat);
        chk(rd == 8'hA5, "R7 dropped write left memory", rd, 8'hA5);

        // R8: access beats retention in the same cycle
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 15'h7F22; ret_req = 1'b1;
        @(negedge clk);
        req = 1'b0; ret_req = 1'b0;
        lat = 1; saw_ready = 1'b0;
        while (!ack && lat < 100) begin
            @(negedge clk);
            lat++;
            if (ret_ready) saw_ready = 1'b1;
        end
        chk(lat == EXP_RD_LAT && rdata == 8'h3C, "R8 access served first", rdata, 8'h3C);
        repeat (5) @(negedge clk);
        chk(!saw_ready && !ret_ready && !busy, "R8 retention dropped", {saw_ready, ret_ready, busy}, 0);

        // R9: retention entry
        @(negedge clk);
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        chk(!ret_ready && busy && mem_cs_n, "R9 deselect before ready", {ret_ready, busy, mem_cs_n}, 3'b011);
        @(negedge clk);
        chk(ret_ready && mem_cs_n, "R9 ready after deselect", {ret_ready, mem_cs_n}, 2'b11);

        // R7: request during retention is dropped
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 15'h0011; wdata = 8'h66;
        @(negedge clk);
        req = 1'b0;
        extra_ack = 0;
        repeat (10) begin
            @(negedge clk);
            if (ack || !mem_cs_n) extra_ack++;
        end
        chk(extra_ack == 0 && ret_ready, "R7 no access in retention", extra_ack, 0);

        // R10: exit and recovery count
        @(negedge clk);
        ret_exit = 1'b1;
        @(negedge clk);
        ret_exit = 1'b0;
        chk(!ret_ready && busy, "R10 ready cleared on exit", {ret_ready, busy}, 2'b01);
        lat = 1;
        while (busy && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == EXP_REC_LAT, "R10 recovery length", lat, EXP_REC_LAT);
        access(1'b0, 15'h0011, 8'h00, rd, lat);
        chk(rd == 8'hA5 && lat == EXP_RD_LAT, "R10 access after recovery", rd, 8'hA5);

        chk(bad_contention == 0, "R5 no contention over whole run", bad_contention, 0);
        chk(bad_write_strobe == 0 && bad_drive == 0, "R2 R3 write strobes over whole run",
            bad_write_strobe + bad_drive, 0);

        summary();
        $finish;
    end

endmodule